// File: doc/BRIEF.md
# Sleep-Level Power Sequencer

This block steps a system between its running state and five sleep levels. Software asks for sleep with a single-cycle enable strobe and a 3-bit level code. The sequencer first asks the memory controller to put SDRAM in self-refresh. When that is acknowledged it applies the clock, PLL and power-pin profile for the chosen level. The profile stays in force until a wake source that the level permits fires.

The exit path depends on depth. Levels 1 and 2 keep all context, so they return to running in one cycle and no reset is issued. Levels 3, 4 and 5 run a power-up sequence in this order:
1. Assert both power-control pins and the power-on pin.
2. Wait a programmable number of slow ticks.
3. Re-enable the PLLs and the auxiliary clocks.
4. Wait a second programmable count.
5. Release self-refresh and pulse a one-cycle system reset.

In levels 4 and 5 a status LED can be held off, held on, or made to blink at one of two rates. On return to running, a throttle-enable input chooses between full-speed and throttled operation. The block has no data stream, so every port is a plain control or status pin.

Top module: `sleep_state_ctrl`

## Requirements
- R1: While running, `slp_en` high with `slp_type` in 1..5 makes `sr_req` 1 and `running` 0 on the next cycle. `slp_en` is a one-cycle strobe.
- R2: While running, `slp_en` with `slp_type` equal to 0, 6 or 7 has no effect: `running` stays 1 and `sr_req` stays 0.
- R3: After a request, `core_clk_en` stays 1 and `pwr_ctl` stays 2'b11 until `sr_ack` has been seen. The profile for the level applies on the cycle after `sr_ack`.
- R4: The level 1 profile is: `core_clk_en`=0, `pll_en`=1, all `aux_clk_en` bits 1, `sr_req`=1, `pwr_ctl`=2'b11, `pwr_on`=1.
- R5: The level 2 profile is: `core_clk_en`=0, `aux_clk_en`=`keep_mask`, `pll_en`=OR of `keep_mask`, `sr_req`=1, `pwr_ctl`=2'b10 (bit 0 is pin 1, deasserted), `pwr_on`=1.
- R6: The level 3 profile is: `core_clk_en`=0, `pll_en`=0, `aux_clk_en`=0, `sr_req`=1, `pwr_ctl`=2'b00, `pwr_on`=1.
- R7: Levels 4 and 5 share one profile: the level 3 profile with `pwr_on`=0.
- R8: The `wake_src` bit positions have these meanings:
  - Bits 0..6 wake every level: power button, button override, thermal, three general wake pins, RTC.
  - Bits 7..10 wake levels 1 and 2 only: USB, audio data-in, infrared receive, ring indicate.
  - Bits 11..15 wake level 1 only: interrupt, SMI, SCI, GPIO, bus-master request.
  - Any other bit leaves the block asleep.
- R9: A permitted wake in level 1 or 2 gives `running`=1, `sr_req`=0 and `sys_rst`=0 on the next cycle.
- R10: A permitted wake in levels 3..5 runs the power-up sequence:
  - First `pwr_ctl`=2'b11 and `pwr_on`=1 with `pll_en`=0, held for `wait_pwr` ticks of `slow_tick`.
  - Then `pll_en`=1 for `wait_pll` ticks.
  - Then one cycle with `sys_rst`=1, `sr_req`=0 and `core_clk_en`=1.
  - Then running.
- R11: `led` is 0 outside levels 4 and 5. Inside them, `led_mode` selects the pattern: 0 gives off, 1 gives on, 2 toggles on every `slow_tick`, 3 toggles every `LED_DIV` ticks.
- R12: `throttle` equals `thr_en` while running and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_en | input | 1 | Sleep request strobe |
| slp_type | input | 3 | Requested level code |
| thr_en | input | 1 | Throttled running selected |
| keep_mask | input | AUX_W | Auxiliary clocks kept on in level 2 |
| led_mode | input | 2 | LED pattern select |
| wait_pwr | input | CNT_W | Ticks between power-on and PLL enable |
| wait_pll | input | CNT_W | Ticks between PLL enable and reset pulse |
| slow_tick | input | 1 | Slow-clock tick strobe |
| sr_ack | input | 1 | Self-refresh acknowledge |
| wake_src | input | 16 | Wake event inputs |
| core_clk_en | output | 1 | Core, memory and display clock enable |
| pll_en | output | 1 | PLL enable |
| aux_clk_en | output | AUX_W | PLL-derived auxiliary clock enables |
| sr_req | output | 1 | SDRAM self-refresh request |
| pwr_ctl | output | 2 | Power-control pins, 1 = asserted |
| pwr_on | output | 1 | Main power-on, 1 = on |
| led | output | 1 | Status LED |
| sys_rst | output | 1 | System reset pulse after deep exit |
| running | output | 1 | Block is in the running state |
| throttle | output | 1 | Throttled running |

## Verification
The assertions assume the following about the inputs:
- `sr_ack` answers a pending request and is otherwise low.
- `slow_tick` and the `wake_src` bits are single-cycle pulses.
- `slp_type` is valid together with the strobe.

The stimulus follows these rules:
- It raises `sr_ack` for exactly one cycle, only after a request, and after a wait of several cycles.
- It pulses each wake bit for one cycle, and only once the block has settled into a level.
- It generates ticks on a fixed period of four cycles.
- It changes the wait counts, keep mask and LED mode only while the block is running.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_SLEEP,
    ST_PU_PWR,
    ST_PU_PLL,
    ST_PU_RST
  } slp_state_e;

  localparam int WAKE_W    = 16;
  localparam int WK_ALL_HI = 6;   // bits 0..6 wake every level
  localparam int WK_MID_HI = 10;  // bits 7..10 wake levels 1 and 2

  function automatic logic type_ok(input logic [2:0] t);
    return (t >= 3'd1) && (t <= 3'd5);
  endfunction

endpackage

// File: rtl/slp_wake_filter.sv
module slp_wake_filter import slp_pkg::*; (
  input  logic [2:0]        level,
  input  logic [WAKE_W-1:0] src,
  output logic              hit
);
  logic [WAKE_W-1:0] allow;

  for (genvar i = 0; i < WAKE_W; i++) begin : g_bit
    if (i <= WK_ALL_HI) begin : g_all
      assign allow[i] = 1'b1;
    end else if (i <= WK_MID_HI) begin : g_mid
      assign allow[i] = (level == 3'd1) || (level == 3'd2);
    end else begin : g_shallow
      assign allow[i] = (level == 3'd1);
    end
  end

  assign hit = |(allow & src);
endmodule

// File: rtl/slp_wait_timer.sv
module slp_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= load_val;
    else if (tick && (cnt != '0))    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R10: the wait count only moves on a slow tick or a load
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/slp_led_gen.sv
module slp_led_gen #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] mode,
  input  logic       tick,
  output logic       led
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          tog;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog  <= 1'b0;
      dcnt <= '0;
    end else if (!active) begin
      tog  <= 1'b0;
      dcnt <= '0;
    end else if (tick) begin
      if (mode == 2'd2) begin
        tog <= ~tog;
      end else if (mode == 2'd3) begin
        if (dcnt == DW'(DIV - 1)) begin
          dcnt <= '0;
          tog  <= ~tog;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  assign led = active && ((mode == 2'd1) || (mode[1] && tog));

  // R11: a blinking pattern changes only on a tick while active
  assert_blink_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && $past(active)) |=> $stable(tog) || !active);
endmodule

// File: rtl/sleep_state_ctrl.sv
module sleep_state_ctrl import slp_pkg::*; #(
  parameter int AUX_W   = 4,
  parameter int CNT_W   = 8,
  parameter int LED_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slp_en,
  input  logic [2:0]        slp_type,
  input  logic              thr_en,
  input  logic [AUX_W-1:0]  keep_mask,
  input  logic [1:0]        led_mode,
  input  logic [CNT_W-1:0]  wait_pwr,
  input  logic [CNT_W-1:0]  wait_pll,
  input  logic              slow_tick,
  input  logic              sr_ack,
  input  logic [15:0]       wake_src,
  output logic              core_clk_en,
  output logic              pll_en,
  output logic [AUX_W-1:0]  aux_clk_en,
  output logic              sr_req,
  output logic [1:0]        pwr_ctl,
  output logic              pwr_on,
  output logic              led,
  output logic              sys_rst,
  output logic              running,
  output logic              throttle
);
  localparam logic [AUX_W-1:0] AUX_ALL = '1;

  slp_state_e        state, state_nx;
  logic [2:0]        lvl;
  logic              wake_hit;
  logic              tmr_zero;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              led_act;
  logic              deep;

  slp_wake_filter u_filter (
    .level (lvl),
    .src   (wake_src),
    .hit   (wake_hit)
  );

  slp_wait_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (slow_tick),
    .zero     (tmr_zero)
  );

  assign led_act = (state == ST_SLEEP) && (lvl >= 3'd4);
  assign deep    = (lvl >= 3'd3);

  slp_led_gen #(.DIV(LED_DIV)) u_led (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (led_act),
    .mode   (led_mode),
    .tick   (slow_tick),
    .led    (led)
  );

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = wait_pwr;
    case (state)
      ST_RUN:    if (slp_en && type_ok(slp_type)) state_nx = ST_ENTER;
      ST_ENTER:  if (sr_ack) state_nx = ST_SLEEP;
      ST_SLEEP: begin
        if (wake_hit) begin
          if (deep) begin
            state_nx = ST_PU_PWR;
            tmr_load = 1'b1;
            tmr_val  = wait_pwr;
          end else begin
            state_nx = ST_RUN;
          end
        end
      end
      ST_PU_PWR: begin
        if (tmr_zero) begin
          state_nx = ST_PU_PLL;
          tmr_load = 1'b1;
          tmr_val  = wait_pll;
        end
      end
      ST_PU_PLL: if (tmr_zero) state_nx = ST_PU_RST;
      ST_PU_RST: state_nx = ST_RUN;
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      lvl   <= 3'd0;
    end else begin
      state <= state_nx;
      if (state == ST_RUN && slp_en && type_ok(slp_type)) lvl <= slp_type;
    end
  end

  always_comb begin
    core_clk_en = 1'b1;
    pll_en      = 1'b1;
    aux_clk_en  = AUX_ALL;
    sr_req      = 1'b0;
    pwr_ctl     = 2'b11;
    pwr_on      = 1'b1;
    case (state)
      ST_ENTER: sr_req = 1'b1;
      ST_SLEEP: begin
        sr_req      = 1'b1;
        core_clk_en = 1'b0;
        if (lvl == 3'd1) begin
          pll_en     = 1'b1;
        end else if (lvl == 3'd2) begin
          aux_clk_en = keep_mask;
          pll_en     = |keep_mask;
          pwr_ctl    = 2'b10;
        end else begin
          aux_clk_en = '0;
          pll_en     = 1'b0;
          pwr_ctl    = 2'b00;
          pwr_on     = (lvl == 3'd3);
        end
      end
      ST_PU_PWR: begin
        sr_req      = 1'b1;
        core_clk_en = 1'b0;
        pll_en      = 1'b0;
        aux_clk_en  = '0;
      end
      ST_PU_PLL: begin
        sr_req      = 1'b1;
        core_clk_en = 1'b0;
      end
      default: ;
    endcase
  end

  assign sys_rst  = (state == ST_PU_RST);
  assign running  = (state == ST_RUN);
  assign throttle = running && thr_en;

  // R1: an accepted request raises self-refresh on the next cycle
  assert_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slp_en && type_ok(slp_type)) |=> (sr_req && !running));

  // R2: an undefined level code is dropped
  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slp_en && !type_ok(slp_type)) |=> running);

  // R3: core clocks stop only after the self-refresh acknowledge
  assert_gate_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(sr_ack));

  // R8: deep levels ignore every source outside the always-on group
  assert_deep_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && deep && wake_src[WK_ALL_HI:0] == '0) |=> (state == ST_SLEEP));

  // R9: shallow exits resume at once without reset
  assert_fast_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !deep && wake_hit) |=> (running && !sys_rst && !sr_req));

  // R10: the reset pulse lasts one cycle and leads to running
  assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (!sys_rst && running));

  // R10: by the reset pulse power and PLLs are up and self-refresh is released
  assert_rst_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (pll_en && pwr_ctl == 2'b11 && pwr_on && !sr_req));

  // R11: the LED shows only while main power is off
  assert_led_R11: assert property (@(posedge clk) disable iff (!rst_n)
    led |-> !pwr_on);
endmodule

// File: tb/sleep_state_ctrl_tb_top.sv
module sleep_state_ctrl_tb_top;
  localparam int AUX_W = 4;
  localparam int CNT_W = 8;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp_en = 1'b0;
  logic [2:0] slp_type = 3'd0;
  logic thr_en = 1'b0;
  logic [AUX_W-1:0] keep_mask = 4'b0101;
  logic [1:0] led_mode = 2'd0;
  logic [CNT_W-1:0] wait_pwr = 8'd3;
  logic [CNT_W-1:0] wait_pll = 8'd2;
  logic slow_tick = 1'b0;
  logic sr_ack = 1'b0;
  logic [15:0] wake_src = 16'h0;
  logic core_clk_en, pll_en, sr_req, pwr_on, led, sys_rst, running, throttle;
  logic [AUX_W-1:0] aux_clk_en;
  logic [1:0] pwr_ctl;

  int checks = 0;
  int errors = 0;
  logic [7:0] tc = 8'd0;

  always #4 clk = ~clk;

  sleep_state_ctrl #(.AUX_W(AUX_W), .CNT_W(CNT_W), .LED_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .slp_en(slp_en), .slp_type(slp_type),
    .thr_en(thr_en), .keep_mask(keep_mask), .led_mode(led_mode),
    .wait_pwr(wait_pwr), .wait_pll(wait_pll), .slow_tick(slow_tick),
    .sr_ack(sr_ack), .wake_src(wake_src), .core_clk_en(core_clk_en),
    .pll_en(pll_en), .aux_clk_en(aux_clk_en), .sr_req(sr_req),
    .pwr_ctl(pwr_ctl), .pwr_on(pwr_on), .led(led), .sys_rst(sys_rst),
    .running(running), .throttle(throttle)
  );

  always @(negedge clk) begin
    tc <= tc + 8'd1;
    slow_tick <= (tc[1:0] == 2'b11);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 run, 1 waiting ack, 2 asleep,
  // 3 power wait, 4 PLL wait, 5 reset pulse
  int m_ph, m_lv, m_cnt, m_div;
  logic m_tog;

  function automatic logic [15:0] allowed(input int lv);
    if (lv == 1) return 16'hFFFF;
    if (lv == 2) return 16'h07FF;
    return 16'h007F;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_lv = 0; m_cnt = 0; m_div = 0; m_tog = 1'b0;
    end else begin
      if (m_ph == 2 && m_lv >= 4) begin
        if (slow_tick && led_mode == 2'd2) m_tog = !m_tog;
        else if (slow_tick && led_mode == 2'd3) begin
          if (m_div == DIV - 1) begin m_div = 0; m_tog = !m_tog; end
          else m_div = m_div + 1;
        end
      end else begin
        m_tog = 1'b0; m_div = 0;
      end
      case (m_ph)
        0: if (slp_en && slp_type >= 3'd1 && slp_type <= 3'd5) begin
             m_lv = int'(slp_type); m_ph = 1;
           end
        1: if (sr_ack) m_ph = 2;
        2: if ((allowed(m_lv) & wake_src) != 16'h0) begin
             if (m_lv <= 2) m_ph = 0;
             else begin m_ph = 3; m_cnt = int'(wait_pwr); end
           end
        3: if (m_cnt == 0) begin m_ph = 4; m_cnt = int'(wait_pll); end
           else if (slow_tick) m_cnt = m_cnt - 1;
        4: if (m_cnt == 0) m_ph = 5;
           else if (slow_tick) m_cnt = m_cnt - 1;
        default: m_ph = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    logic e_core, e_pll, e_sr, e_on, e_led;
    logic [AUX_W-1:0] e_aux;
    logic [1:0] e_pwr;
    string tg;
    #2;
    if (rst_n) begin
      e_core = (m_ph == 0 || m_ph == 1 || m_ph == 5);
      e_sr   = (m_ph >= 1 && m_ph <= 4);
      e_pll = 1'b1; e_aux = '1; e_pwr = 2'b11; e_on = 1'b1;
      if (m_ph == 3) begin e_pll = 1'b0; e_aux = '0; end
      if (m_ph == 2) begin
        if (m_lv == 2) begin e_aux = keep_mask; e_pll = |keep_mask; e_pwr = 2'b10; end
        else if (m_lv >= 3) begin
          e_aux = '0; e_pll = 1'b0; e_pwr = 2'b00; e_on = (m_lv == 3);
        end
      end
      e_led = (m_ph == 2 && m_lv >= 4) && (led_mode == 2'd1 || (led_mode[1] && m_tog));
      if (m_ph == 2) tg = (m_lv == 1) ? "R4" : (m_lv == 2) ? "R5" : (m_lv == 3) ? "R6" : "R7";
      else if (m_ph >= 3) tg = "R10";
      else tg = "R1";
      chk({tg, " core_clk_en"}, core_clk_en, e_core);
      chk({tg, " pll_en"}, pll_en, e_pll);
      chk({tg, " aux_clk_en"}, aux_clk_en, e_aux);
      chk({tg, " sr_req"}, sr_req, e_sr);
      chk({tg, " pwr_ctl"}, pwr_ctl, e_pwr);
      chk({tg, " pwr_on"}, pwr_on, e_on);
      chk("R10 sys_rst", sys_rst, m_ph == 5);
      chk("R1 running", running, m_ph == 0);
      chk("R11 led", led, e_led);
      chk("R12 throttle", throttle, (m_ph == 0) && thr_en);
    end
  end

  task automatic do_sleep(input int lv, input logic [15:0] bad, input logic [15:0] good, input int hold);
    string lt;
    lt = (lv == 1) ? "R4" : (lv == 2) ? "R5" : (lv == 3) ? "R6" : "R7";
    @(negedge clk); slp_type = lv[2:0]; slp_en = 1'b1;
    @(negedge clk); slp_en = 1'b0;
    chk("R1 request accepted", {sr_req, running}, 2'b10);
    repeat (3) @(negedge clk);
    chk("R3 held before ack", {core_clk_en, pwr_ctl}, 3'b111);
    sr_ack = 1'b1;
    @(negedge clk); sr_ack = 1'b0;
    chk({lt, " profile applied"}, {sr_req, core_clk_en}, 2'b10);
    if (lv == 2) chk("R5 keep mask", aux_clk_en, keep_mask);
    if (lv >= 4) chk("R7 power-on off", pwr_on, 1'b0);
    repeat (hold) @(negedge clk);
    if (lv >= 4 && led_mode == 2'd1) chk("R11 steady on", led, 1'b1);
    if (lv <= 3 || led_mode == 2'd0) chk("R11 led off", led, 1'b0);
    if (bad != 16'h0) begin
      wake_src = bad;
      @(negedge clk); wake_src = 16'h0;
      chk("R8 blocked wake", {running, sr_req}, 2'b01);
    end
    wake_src = good;
    @(negedge clk); wake_src = 16'h0;
    if (lv <= 2) begin
      chk("R9 fast resume", {running, sr_req, sys_rst}, 3'b100);
    end else begin
      int rc = 0;
      int n = 0;
      chk("R10 power first", {pwr_ctl, pwr_on, pll_en}, 4'b1110);
      while (!running && n < 2000) begin
        if (sys_rst) rc++;
        @(negedge clk);
        n++;
      end
      chk("R10 sequence end", {running, rc[3:0]}, {1'b1, 4'd1});
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {running, sr_req, core_clk_en, sys_rst, led}, 5'b10100);
    // R2: undefined level codes
    for (int k = 0; k < 3; k++) begin
      slp_type = (k == 0) ? 3'd0 : (k == 1) ? 3'd6 : 3'd7;
      slp_en = 1'b1;
      @(negedge clk); slp_en = 1'b0;
      chk("R2 code ignored", {running, sr_req}, 2'b10);
    end
    // R12
    thr_en = 1'b1;
    @(negedge clk);
    chk("R12 throttled", throttle, 1'b1);
    thr_en = 1'b0;
    @(negedge clk);
    chk("R12 full speed", throttle, 1'b0);

    do_sleep(1, 16'h0, 16'h1000, 4);
    do_sleep(2, 16'h0800, 16'h0100, 6);
    do_sleep(3, 16'h0200, 16'h0001, 5);
    led_mode = 2'd2;
    do_sleep(4, 16'h8000, 16'h0040, 40);
    led_mode = 2'd3;
    do_sleep(5, 16'h0080, 16'h0008, 60);
    led_mode = 2'd1;
    do_sleep(5, 16'h0, 16'h0002, 5);
    led_mode = 2'd0;
    wait_pwr = 8'd0; wait_pll = 8'd0;
    do_sleep(3, 16'h0, 16'h0020, 3);
    wait_pwr = 8'd5; wait_pll = 8'd1;
    do_sleep(4, 16'h0400, 16'h0004, 8);
    do_sleep(1, 16'h0, 16'h8000, 3);
    keep_mask = 4'b0000;
    do_sleep(2, 16'h0, 16'h0400, 4);
    thr_en = 1'b1;
    @(negedge clk);
    chk("R12 throttle after wake", throttle, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual hang expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule